// File: doc/BRIEF.md
# Threshold Byte FIFO with Status Window

This block sits between a serial-bus byte engine and a byte-wide register port. It holds one byte queue for outgoing data and one for incoming data. Software pushes transmit bytes and pops receive bytes through a single data register. The engine takes transmit bytes and delivers receive bytes through simple one-cycle strobes. The control and status registers share a small address window, and a bank-select bit switches between the mode register and the queue registers.

Each direction has a programmable threshold with a sticky "threshold reached" flag. A sticky event flag reports that the transmit queue has drained or that the receive queue has filled. A self-clearing flush command empties both queues. The block also provides a combined interrupt and a receive-ready indication, which is withheld while software waits for a full receive queue. A "last byte" marker tells the engine when the next incoming byte completes the programmed receive count, so the engine can finish the read.

Top module: `thresh_fifo`

## Requirements
- R1: After reset every register reads 0x00, both queues are empty, `fifoIrq` is 0 and `dataReady` is 1.
- R2: Bit 5 of the bank register at offset 0x0E selects the bank. In bank 0, offset 0x10 is the mode register, with the enable in bit 4. In bank 1 the queue registers are: 0x10 control/status (bit 6 flush, bit 3 event interrupt enable, bit 1 event flag); 0x12 transmit control (bit 6 interrupt enable, bits 4:0 threshold); 0x14 transmit status; 0x16 receive control (bit 6 interrupt enable, bit 5 last marker, bits 4:0 threshold); 0x18 receive status. In both status registers bit 6 is the threshold flag and bits 4:0 are the byte count. Any other offset, and any bank-1 offset in bank 0, reads 0x00.
- R3: Bytes written to the data register at offset 0x00 leave on `busTxData` in first-in order. Bytes pushed on `busRxData` read back from offset 0x00 in the same order, and each read of offset 0x00 pops one byte. An empty receive queue reads 0x00.
- R4: Each queue holds 16 bytes. A push into a full queue and a pop from an empty queue are ignored. When a push and a pop arrive in the same cycle, each is judged against the count before that cycle.
- R5: While the enable is 0, data-register writes and reads, `busTxPop` and `busRxPush` leave both queues unchanged.
- R6: Writing bit 6 set to the control/status register empties both queues and clears every threshold and event flag. This takes priority over a same-cycle bus push. The bit always reads back 0.
- R7: The transmit threshold flag sets when an accepted pop leaves the transmit count at or below the threshold. Writing 1 to status bit 6 clears it, and a same-cycle set wins.
- R8: The receive threshold flag sets when an accepted push brings the receive count equal to the threshold. Writing 1 to status bit 6 clears it, and a same-cycle set wins.
- R9: The event flag sets when an accepted transmit pop empties the transmit queue, or when an accepted receive push makes the receive queue hold 16 bytes. Writing 1 to bit 1 clears it, and a same-cycle set wins.
- R10: `fifoIrq` is high when the enable is 1 and at least one flag has its own enable set: the transmit flag with transmit bit 6, the receive flag with receive bit 6, or the event flag with control/status bit 3.
- R11: `dataReady` is 0 only when the enable is 1, the receive interrupt enable is 1 and fewer than 16 bytes are held.
- R12: `busRxFinal` is high when the enable is 1, the last marker is 1 and the receive count plus one equals the receive threshold.
- R13: `busTxAvail` is high when the enable is 1 and the transmit queue is not empty. `busRxRoom` is high when the enable is 1 and the receive queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 5 | Register offset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (pops on offset 0x00) |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data, combinational from `regAddr` |
| busTxData | output | 8 | Head of the transmit queue |
| busTxAvail | output | 1 | Transmit byte available |
| busTxPop | input | 1 | Engine takes the transmit head |
| busRxData | input | 8 | Byte from the engine |
| busRxPush | input | 1 | Engine delivers `busRxData` |
| busRxRoom | output | 1 | Receive queue can accept a byte |
| busRxFinal | output | 1 | Next received byte completes the programmed count |
| dataReady | output | 1 | Receive-ready indication |
| fifoIrq | output | 1 | Combined threshold and event interrupt |

## Verification
The bench builds the block with its default depth of 16, which keeps the full-queue cases within a short run: the 16-byte ready rule, the receive-full event and the ignored seventeenth push. With that depth, random thresholds from 0 to 17 cover values that are never reached as well as the exact-match and at-or-below boundaries. Random traffic also flips the bank and the enable, so bank-0 reads of bank-1 offsets and disabled handshakes occur often.

// File: rtl/thresh_fifo_pkg.sv
`timescale 1ns/1ps
package thresh_fifo_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 5;
  localparam int FIELD_W = 5;

  localparam logic [ADDR_W-1:0] ADR_DATA = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_BANK = 5'h0E;
  localparam logic [ADDR_W-1:0] ADR_MODE = 5'h10;  // bank 0
  localparam logic [ADDR_W-1:0] ADR_FCS  = 5'h10;  // bank 1
  localparam logic [ADDR_W-1:0] ADR_TXC  = 5'h12;
  localparam logic [ADDR_W-1:0] ADR_TXS  = 5'h14;
  localparam logic [ADDR_W-1:0] ADR_RXC  = 5'h16;
  localparam logic [ADDR_W-1:0] ADR_RXS  = 5'h18;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic flush;
  } qStrobe_t;
endpackage

// File: rtl/thresh_fifo_queue.sv
`timescale 1ns/1ps
module thresh_fifo_queue #(
  parameter int DEPTH = 16,
  parameter int W = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rdPtr, wrPtr;
  logic          pushOk, popOk;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  assign pushOk = push && (count != FULL) && !flush;
  assign popOk  = pop && (count != '0) && !flush;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk)  rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(pushOk) - CW'(popOk);
    end
  end

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= wdata;
  end

  assign rdata = (count != '0) ? mem[rdPtr] : '0;
endmodule

// File: rtl/thresh_fifo_dp.sv
`timescale 1ns/1ps
module thresh_fifo_dp
  import thresh_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobe_t          stb,
  input  logic [DATA_W-1:0] txWdata,
  input  logic [DATA_W-1:0] rxWdata,
  output logic [DATA_W-1:0] txHead,
  output logic [DATA_W-1:0] rxHead,
  output logic [CW-1:0]     txCount,
  output logic [CW-1:0]     rxCount
);
  thresh_fifo_queue #(.DEPTH(DEPTH), .W(DATA_W)) uTxQ (
    .clk(clk), .rstN(rstN), .flush(stb.flush),
    .push(stb.txPush), .pop(stb.txPop),
    .wdata(txWdata), .rdata(txHead), .count(txCount)
  );

  thresh_fifo_queue #(.DEPTH(DEPTH), .W(DATA_W)) uRxQ (
    .clk(clk), .rstN(rstN), .flush(stb.flush),
    .push(stb.rxPush), .pop(stb.rxPop),
    .wdata(rxWdata), .rdata(rxHead), .count(rxCount)
  );
endmodule

// File: rtl/thresh_fifo_ctrl.sv
`timescale 1ns/1ps
module thresh_fifo_ctrl
  import thresh_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              busTxPop,
  input  logic              busRxPush,
  input  logic [CW-1:0]     txCount,
  input  logic [CW-1:0]     rxCount,
  input  logic [DATA_W-1:0] rxHead,
  output qStrobe_t          stb,
  output logic              busTxAvail,
  output logic              busRxRoom,
  output logic              busRxFinal,
  output logic              dataReady,
  output logic              fifoIrq,
  output logic              bankSel,
  output logic              fifoEn
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic               fcsIe, evtFlag;
  logic               txIe, txHit, rxIe, rxLast, rxHit;
  logic [FIELD_W-1:0] txThr, rxThr;

  logic selData, selBank, selMode, selFcs, selTxc, selTxs, selRxc, selRxs;
  logic flushReq;
  logic txPushOk, txPopOk, rxPushOk, rxPopOk;
  logic [CW-1:0] txNext, rxNext;
  logic txHitSet, rxHitSet, evtSet;

  // address decode
  assign selData = (regAddr == ADR_DATA);
  assign selBank = (regAddr == ADR_BANK);
  assign selMode = !bankSel && (regAddr == ADR_MODE);
  assign selFcs  = bankSel && (regAddr == ADR_FCS);
  assign selTxc  = bankSel && (regAddr == ADR_TXC);
  assign selTxs  = bankSel && (regAddr == ADR_TXS);
  assign selRxc  = bankSel && (regAddr == ADR_RXC);
  assign selRxs  = bankSel && (regAddr == ADR_RXS);

  assign flushReq = regWr && selFcs && regWdata[6];

  // strobes toward the datapath
  always_comb begin
    stb.flush  = flushReq;
    stb.txPush = fifoEn && regWr && selData;
    stb.rxPop  = fifoEn && regRd && selData;
    stb.txPop  = fifoEn && busTxPop;
    stb.rxPush = fifoEn && busRxPush;
  end

  // accepted operations and resulting counts
  assign txPushOk = stb.txPush && (txCount != FULL) && !flushReq;
  assign txPopOk  = stb.txPop && (txCount != '0) && !flushReq;
  assign rxPushOk = stb.rxPush && (rxCount != FULL) && !flushReq;
  assign rxPopOk  = stb.rxPop && (rxCount != '0) && !flushReq;
  assign txNext   = txCount + CW'(txPushOk) - CW'(txPopOk);
  assign rxNext   = rxCount + CW'(rxPushOk) - CW'(rxPopOk);

  assign txHitSet = txPopOk && (FIELD_W'(txNext) <= txThr);
  assign rxHitSet = rxPushOk && (FIELD_W'(rxNext) == rxThr);
  assign evtSet   = (txPopOk && (txNext == '0)) || (rxPushOk && (rxNext == FULL));

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankSel <= 1'b0;
      fifoEn  <= 1'b0;
      fcsIe   <= 1'b0;
      txIe    <= 1'b0;
      txThr   <= '0;
      rxIe    <= 1'b0;
      rxLast  <= 1'b0;
      rxThr   <= '0;
    end else if (regWr) begin
      if (selBank) bankSel <= regWdata[5];
      if (selMode) fifoEn  <= regWdata[4];
      if (selFcs)  fcsIe   <= regWdata[3];
      if (selTxc) begin
        txIe  <= regWdata[6];
        txThr <= regWdata[FIELD_W-1:0];
      end
      if (selRxc) begin
        rxIe   <= regWdata[6];
        rxLast <= regWdata[5];
        rxThr  <= regWdata[FIELD_W-1:0];
      end
    end
  end

  // sticky flags: flush first, then set, then write-1-to-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHit   <= 1'b0;
      rxHit   <= 1'b0;
      evtFlag <= 1'b0;
    end else if (flushReq) begin
      txHit   <= 1'b0;
      rxHit   <= 1'b0;
      evtFlag <= 1'b0;
    end else begin
      if (txHitSet) txHit <= 1'b1;
      else if (regWr && selTxs && regWdata[6]) txHit <= 1'b0;
      if (rxHitSet) rxHit <= 1'b1;
      else if (regWr && selRxs && regWdata[6]) rxHit <= 1'b0;
      if (evtSet) evtFlag <= 1'b1;
      else if (regWr && selFcs && regWdata[1]) evtFlag <= 1'b0;
    end
  end

  // read mux
  always_comb begin
    regRdata = '0;
    if (selData)      regRdata = rxHead;
    else if (selBank) regRdata = {2'b00, bankSel, 5'b00000};
    else if (selMode) regRdata = {3'b000, fifoEn, 4'b0000};
    else if (selFcs)  regRdata = {4'b0000, fcsIe, 1'b0, evtFlag, 1'b0};
    else if (selTxc)  regRdata = {1'b0, txIe, 1'b0, txThr};
    else if (selTxs)  regRdata = {1'b0, txHit, 1'b0, FIELD_W'(txCount)};
    else if (selRxc)  regRdata = {1'b0, rxIe, rxLast, rxThr};
    else if (selRxs)  regRdata = {1'b0, rxHit, 1'b0, FIELD_W'(rxCount)};
  end

  // status toward engine and host
  assign busTxAvail = fifoEn && (txCount != '0);
  assign busRxRoom  = fifoEn && (rxCount != FULL);
  assign busRxFinal = fifoEn && rxLast && ((FIELD_W'(rxCount) + FIELD_W'(1)) == rxThr);
  assign dataReady  = !(fifoEn && rxIe && (rxCount != FULL));
  assign fifoIrq    = fifoEn && ((txIe && txHit) || (rxIe && rxHit) || (fcsIe && evtFlag));
endmodule

// File: rtl/thresh_fifo.sv
`timescale 1ns/1ps
module thresh_fifo
  import thresh_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] busTxData,
  output logic              busTxAvail,
  input  logic              busTxPop,
  input  logic [DATA_W-1:0] busRxData,
  input  logic              busRxPush,
  output logic              busRxRoom,
  output logic              busRxFinal,
  output logic              dataReady,
  output logic              fifoIrq
);
  localparam int CW = $clog2(DEPTH + 1);

  qStrobe_t          stb;
  logic [CW-1:0]     txCount, rxCount;
  logic [DATA_W-1:0] rxHead;
  logic              bankSel, fifoEn;

  thresh_fifo_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata),
    .busTxPop(busTxPop), .busRxPush(busRxPush),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead),
    .stb(stb),
    .busTxAvail(busTxAvail), .busRxRoom(busRxRoom), .busRxFinal(busRxFinal),
    .dataReady(dataReady), .fifoIrq(fifoIrq),
    .bankSel(bankSel), .fifoEn(fifoEn)
  );

  thresh_fifo_dp #(.DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .txWdata(regWdata), .rxWdata(busRxData),
    .txHead(busTxData), .rxHead(rxHead),
    .txCount(txCount), .rxCount(rxCount)
  );
endmodule

// File: rtl/thresh_fifo_chk.sv
`timescale 1ns/1ps
module thresh_fifo_chk
  import thresh_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWr,
  input logic              regRd,
  input logic [DATA_W-1:0] regWdata,
  input logic              busTxPop,
  input logic              busTxAvail,
  input logic              fifoIrq,
  input logic              bankSel,
  input logic              fifoEn,
  input logic [CW-1:0]     txCount,
  input logic [CW-1:0]     rxCount
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= FULL) && (rxCount <= FULL));

  p_full_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == FULL) && !regWr && !regRd |=> rxCount == FULL);

  p_pop_dec_r3: assert property (@(posedge clk) disable iff (!rstN)
    busTxPop && busTxAvail && !regWr |=> txCount == $past(txCount) - CW'(1));

  p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEn && !regWr |=> $stable(txCount) && $stable(rxCount));

  p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    regWr && bankSel && (regAddr == ADR_FCS) && regWdata[6] |=> (txCount == '0) && (rxCount == '0));

  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rstN)
    fifoIrq |-> fifoEn);
endmodule

bind thresh_fifo thresh_fifo_chk #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
  .regWdata(regWdata), .busTxPop(busTxPop), .busTxAvail(busTxAvail),
  .fifoIrq(fifoIrq), .bankSel(bankSel), .fifoEn(fifoEn),
  .txCount(txCount), .rxCount(rxCount)
);

// File: tb/thresh_fifo_test.sv
`timescale 1ns/1ps
module thresh_fifo_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] regAddr = '0;
  logic       regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWdata = '0, regRdata, busTxData, busRxData = '0;
  logic       busTxAvail, busTxPop = 1'b0, busRxPush = 1'b0;
  logic       busRxRoom, busRxFinal, dataReady, fifoIrq;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  thresh_fifo uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .busTxData(busTxData),
    .busTxAvail(busTxAvail), .busTxPop(busTxPop), .busRxData(busRxData),
    .busRxPush(busRxPush), .busRxRoom(busRxRoom), .busRxFinal(busRxFinal),
    .dataReady(dataReady), .fifoIrq(fifoIrq)
  );

  // reference model state
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];
  bit mBank, mEn, mFcsIe, mEvt, mTxIe, mTxHit, mRxIe, mRxLast, mRxHit;
  logic [4:0] mTxThr, mRxThr;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [4:0] a);
    logic [4:0] tc, rc;
    tc = 5'(txQ.size());
    rc = 5'(rxQ.size());
    if (a == 5'h00) return (rxQ.size() != 0) ? rxQ[0] : 8'h00;
    if (a == 5'h0E) return {2'b00, mBank, 5'b0};
    if (!mBank) return (a == 5'h10) ? {3'b000, mEn, 4'b0} : 8'h00;
    case (a)
      5'h10: return {4'b0, mFcsIe, 1'b0, mEvt, 1'b0};
      5'h12: return {1'b0, mTxIe, 1'b0, mTxThr};
      5'h14: return {1'b0, mTxHit, 1'b0, tc};
      5'h16: return {1'b0, mRxIe, mRxLast, mRxThr};
      5'h18: return {1'b0, mRxHit, 1'b0, rc};
      default: return 8'h00;
    endcase
  endfunction

  task automatic modelUpdate(input logic [4:0] a, input bit w, input bit r, input logic [7:0] d,
                             input bit tp, input bit rp, input logic [7:0] rdat);
    bit fl, txPu, txPo, rxPu, rxPo;
    int tn, rn;
    fl   = w && mBank && a == 5'h10 && d[6];
    txPu = mEn && w && a == 5'h00 && txQ.size() < 16 && !fl;
    txPo = mEn && tp && txQ.size() > 0 && !fl;
    rxPu = mEn && rp && rxQ.size() < 16 && !fl;
    rxPo = mEn && r && a == 5'h00 && rxQ.size() > 0 && !fl;
    tn = txQ.size() + int'(txPu) - int'(txPo);
    rn = rxQ.size() + int'(rxPu) - int'(rxPo);
    if (fl) begin
      mTxHit = 0; mRxHit = 0; mEvt = 0;
      txQ.delete(); rxQ.delete();
    end else begin
      if (txPo && tn <= int'(mTxThr)) mTxHit = 1;
      else if (w && mBank && a == 5'h14 && d[6]) mTxHit = 0;
      if (rxPu && rn == int'(mRxThr)) mRxHit = 1;
      else if (w && mBank && a == 5'h18 && d[6]) mRxHit = 0;
      if ((txPo && tn == 0) || (rxPu && rn == 16)) mEvt = 1;
      else if (w && mBank && a == 5'h10 && d[1]) mEvt = 0;
      if (txPo) void'(txQ.pop_front());
      if (rxPo) void'(rxQ.pop_front());
      if (txPu) txQ.push_back(d);
      if (rxPu) rxQ.push_back(rdat);
    end
    if (w) begin
      if (a == 5'h10 && mBank) mFcsIe = d[3];
      if (a == 5'h10 && !mBank) mEn = d[4];
      if (a == 5'h12 && mBank) begin mTxIe = d[6]; mTxThr = d[4:0]; end
      if (a == 5'h16 && mBank) begin mRxIe = d[6]; mRxLast = d[5]; mRxThr = d[4:0]; end
      if (a == 5'h0E) mBank = d[5];
    end
  endtask

  task automatic step(input logic [4:0] a, input bit w, input bit r, input logic [7:0] d,
                      input bit tp, input bit rp, input logic [7:0] rdat, input string tag);
    bit eAvail;
    regAddr = a; regWr = w; regRd = r; regWdata = d;
    busTxPop = tp; busRxPush = rp; busRxData = rdat;
    #1;
    eAvail = mEn && txQ.size() != 0;
    if (r) chk(tag, regRdata, expRead(a));
    chk("R13 avail/room", {6'b0, busTxAvail, busRxRoom}, {6'b0, eAvail, mEn && rxQ.size() < 16});
    if (eAvail) chk("R3 tx order", busTxData, txQ[0]);
    chk("R11 ready", {7'b0, dataReady}, {7'b0, !(mEn && mRxIe && rxQ.size() < 16)});
    chk("R10 irq", {7'b0, fifoIrq},
        {7'b0, mEn && ((mTxIe && mTxHit) || (mRxIe && mRxHit) || (mFcsIe && mEvt))});
    chk("R12 final", {7'b0, busRxFinal},
        {7'b0, mEn && mRxLast && (rxQ.size() + 1 == int'(mRxThr))});
    modelUpdate(a, w, r, d, tp, rp, rdat);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    step(a, 1, 0, d, 0, 0, 8'h00, "write");
  endtask
  task automatic rd(input logic [4:0] a, input string tag);
    step(a, 0, 1, 8'h00, 0, 0, 8'h00, tag);
  endtask
  task automatic popTx();
    step(5'h01, 0, 0, 8'h00, 1, 0, 8'h00, "pop");
  endtask
  task automatic pushRx(input logic [7:0] v);
    step(5'h01, 0, 0, 8'h00, 0, 1, v, "push");
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [4:0] wa;
    logic [7:0] wd;
    int op;
    void'($urandom(32'h0C0FFEE5));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset values
    rd(5'h0E, "R1 bank reset");
    rd(5'h10, "R1 mode reset");
    // R2: bank switching and map
    wr(5'h0E, 8'h20);
    rd(5'h0E, "R2 bank readback");
    rd(5'h10, "R1 fcs reset");
    rd(5'h14, "R1 txs reset");
    rd(5'h18, "R1 rxs reset");
    rd(5'h1A, "R2 unmapped");
    wr(5'h12, 8'h45);
    rd(5'h12, "R2 txc readback");
    wr(5'h0E, 8'h00);
    rd(5'h12, "R2 bank0 hides txc");
    // R5: disabled handshakes ignored
    pushRx(8'h11);
    wr(5'h00, 8'h22);
    popTx();
    rd(5'h00, "R5 data while disabled");
    wr(5'h0E, 8'h20);
    rd(5'h14, "R5 tx count stays 0");
    rd(5'h18, "R5 rx count stays 0");
    // enable
    wr(5'h0E, 8'h00);
    wr(5'h10, 8'h10);
    rd(5'h10, "R2 mode enable");
    wr(5'h0E, 8'h20);
    // R3/R4/R7/R9: transmit path
    wr(5'h12, 8'h41);
    wr(5'h00, 8'hA1);
    wr(5'h00, 8'hA2);
    wr(5'h00, 8'hA3);
    rd(5'h14, "R4 tx count 3");
    popTx();
    popTx();
    rd(5'h14, "R7 tx hit at threshold");
    wr(5'h14, 8'h40);
    rd(5'h14, "R7 tx hit cleared");
    popTx();
    rd(5'h10, "R9 drain event");
    wr(5'h10, 8'h02);
    rd(5'h10, "R9 event cleared");
    popTx();
    rd(5'h14, "R4 pop on empty ignored");
    // R8/R11: receive threshold 1
    wr(5'h16, 8'h41);
    pushRx(8'h5C);
    rd(5'h18, "R8 rx hit and count 1");
    rd(5'h00, "R8 pop returns byte");
    rd(5'h18, "R8 count back to 0");
    // R4/R9: fill receive queue
    for (int i = 0; i < 16; i++) pushRx(8'(8'h80 + i));
    rd(5'h10, "R9 rx full event");
    pushRx(8'hEE);
    rd(5'h18, "R4 push on full ignored");
    rd(5'h00, "R3 rx order head");
    rd(5'h00, "R3 rx order next");
    // R6: flush
    wr(5'h00, 8'h33);
    step(5'h10, 1, 0, 8'h48, 0, 1, 8'h77, "R6 flush with push");
    rd(5'h10, "R6 flush bit reads 0");
    rd(5'h14, "R6 tx emptied");
    rd(5'h18, "R6 rx emptied");
    // R12: last marker
    wr(5'h16, 8'h23);
    pushRx(8'h01);
    pushRx(8'h02);
    pushRx(8'h03);
    rd(5'h18, "R8 rx hit at 3");

    // random phase
    for (int n = 0; n < 5000; n++) begin
      op = $urandom_range(0, 9);
      case (op)
        0, 1, 2: step(5'h01, 0, 0, 8'h00, 1, $urandom_range(0, 1) == 1, 8'($urandom), "R3 rand");
        3, 4: step(5'h01, 0, 0, 8'h00, $urandom_range(0, 1) == 1, 1, 8'($urandom), "R3 rand");
        5: step(5'h00, 1, 0, 8'($urandom), $urandom_range(0, 1) == 1, 0, 8'h00, "R3 rand");
        6: step(5'h00, 0, 1, 8'h00, 0, $urandom_range(0, 1) == 1, 8'($urandom), "R3 rand pop");
        7: begin
          case ($urandom_range(0, 5))
            0: wa = 5'h0E;
            1: wa = 5'h10;
            2: wa = 5'h12;
            3: wa = 5'h14;
            4: wa = 5'h16;
            default: wa = 5'h18;
          endcase
          wd = 8'($urandom);
          wd[4:0] = 5'($urandom_range(0, 17));
          if (wa == 5'h10) begin
            wd[6] = ($urandom_range(0, 7) == 0);
            wd[4] = ($urandom_range(0, 9) != 0);
          end
          step(wa, 1, 0, wd, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 8'($urandom), "R2 rand");
        end
        8: step(5'($urandom), 0, 1, 8'h00, 0, 0, 8'h00, "R2 rand read");
        default: step(5'h01, 0, 0, 8'h00, $urandom_range(0, 1) == 1,
                      $urandom_range(0, 1) == 1, 8'($urandom), "R4 rand");
      endcase
    end
    regWr = 0; regRd = 0; busTxPop = 0; busRxPush = 0;
    report();
  end
endmodule